// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank-State Checker

This block watches the command pins of a four-bank SDRAM from the device side. On every clock edge whose preceding clock-enable sample was high, it reads chip select, the three strobes, the two bank-select bits and the address. It turns them into one command and reports that command on a registered result port. The report carries the command code, the target bank, the row or column address, the auto-precharge and all-banks qualifiers, and a flag that marks the command as illegal for the current bank state.

A small tracker per bank follows it through idle, row open, read burst, write burst and precharge. It uses a programmable burst length and a parameterised precharge time. An illegal command is reported but changes no bank state. Deselect cycles and clock-suspended edges produce no report, but bursts and precharge timers that are already running continue through deselect cycles.

The result port is a one-way stream with a valid strobe and no ready. The block cannot stall the command bus, so the consumer must accept one report per accepted command in the cycle it appears. `res_valid` is high for exactly one cycle per accepted command.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A cycle with `cs_n` high is a deselect. It produces no report (`res_valid` low in the following cycle), but running bursts and precharge timers keep counting.
- R2: With `cs_n` low, `{ras_n,cas_n,we_n}` decodes to a command code on `res_cmd`: 111 and 110 give NOP (0), 101 gives READ (1), 100 gives WRITE (2), 011 gives ACTIVATE (3), 010 gives PRECHARGE (4), 001 gives REFRESH (5), 000 gives MODE SET (6).
- R3: The bank index is `{ba[0], ba[1]}`, with `ba[0]` as the upper bit. So `ba=2'b10` addresses bank 1 and `ba=2'b01` addresses bank 2.
- R4: `res_addr` carries the full 13-bit `addr` for ACTIVATE. For READ and WRITE it carries `addr[COL_W-1:0]` zero-extended (COL_W=9). For all other commands it carries `addr` unchanged.
- R5: `addr[10]` high sets `res_auto_pre` on READ and WRITE, and sets `res_all_banks` on PRECHARGE. Otherwise both flags are low.
- R6: READ or WRITE to an idle or precharging bank is illegal. ACTIVATE to any bank that is not idle is illegal.
- R7: REFRESH and MODE SET are illegal unless all four banks are idle.
- R8: PRECHARGE is never illegal. On an idle or precharging bank it has no effect. With `addr[10]` high it closes every open bank.
- R9: READ or WRITE during a plain read or write burst on that bank is legal and restarts the burst. READ or WRITE during an auto-precharge burst on that bank is illegal.
- R10: A burst lasts 2^`bl_sel` clocks (`bl_sel` 0..3 gives 1, 2, 4, 8). It then returns to row open, or enters precharge if auto-precharge was set. A bank precharges for TRP_CYC clocks (default 3) before it is idle again.
- R11: If `cke` was low at the previous edge, the current edge is suspended. The command is not accepted and all bank state holds.
- R12: A report appears in the cycle after the accepting edge, and is judged against the bank state before that edge. An illegal command changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low suspends the next edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable |
| ba | input | 2 | Bank select bits, ba[0] is the upper index bit |
| addr | input | 13 | Row / column / qualifier address |
| bl_sel | input | 2 | Burst length select, length = 2^bl_sel |
| res_valid | output | 1 | One-cycle strobe per accepted command |
| res_cmd | output | 3 | Decoded command code |
| res_bank | output | 2 | Target bank index |
| res_addr | output | 13 | Row or column address |
| res_auto_pre | output | 1 | READ/WRITE with auto-precharge |
| res_all_banks | output | 1 | PRECHARGE applies to all banks |
| res_illegal | output | 1 | Command is illegal in the current state |

## Verification
The in-line assertions check the cycle-level rules on every cycle. Deselect and suspended edges must never produce a report. Clock suspend must freeze each bank. A legal ACTIVATE must open its bank. PRECHARGE on an idle bank must leave it idle. An expiring precharge timer must return the bank to idle. A REFRESH issued with any bank busy must be flagged. The scoreboard scenarios cover what needs a history: exact burst and precharge durations seen through the illegal flag at the boundary cycle, burst restart and termination, the auto-precharge lockout, the bank-bit mapping, and the address selection per command.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_ACT   = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_REF   = 3'd5,
    CMD_MRS   = 3'd6,
    CMD_DESEL = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_OPEN   = 3'd1,
    BK_RD     = 3'd2,
    BK_WR     = 3'd3,
    BK_PRECHG = 3'd4
  } bank_st_e;

  localparam int QUAL_BIT = 10;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;   // 111 and 110
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_mon_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int TRP_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go,
  input  cmd_e             cmd,
  input  logic             ap_in,
  input  logic [CNT_W-1:0] bl_m1,
  output bank_st_e         state,
  output logic             rw_bad,
  output logic             act_bad
);
  localparam logic [CNT_W-1:0] TRP_LOAD = CNT_W'(TRP_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             ap_q;

  assign rw_bad  = (state == BK_IDLE) || (state == BK_PRECHG) ||
                   (((state == BK_RD) || (state == BK_WR)) && ap_q);
  assign act_bad = (state != BK_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= BK_IDLE;
      cnt   <= '0;
      ap_q  <= 1'b0;
    end else if (tick) begin
      if (go && (cmd == CMD_ACT)) begin
        state <= BK_OPEN;
      end else if (go && ((cmd == CMD_READ) || (cmd == CMD_WRITE))) begin
        state <= (cmd == CMD_READ) ? BK_RD : BK_WR;
        cnt   <= bl_m1;
        ap_q  <= ap_in;
      end else if (go && (cmd == CMD_PRE) &&
                   (state != BK_IDLE) && (state != BK_PRECHG)) begin
        state <= BK_PRECHG;
        cnt   <= TRP_LOAD;
        ap_q  <= 1'b0;
      end else begin
        unique case (state)
          BK_RD, BK_WR: begin
            if (cnt == '0) begin
              if (ap_q) begin
                state <= BK_PRECHG;
                cnt   <= TRP_LOAD;
                ap_q  <= 1'b0;
              end else begin
                state <= BK_OPEN;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          BK_PRECHG: begin
            if (cnt == '0) state <= BK_IDLE;
            else           cnt   <= cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  a_r6_act_opens_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && go && (cmd == CMD_ACT)) |=> (state == BK_OPEN));

  a_r8_pre_on_idle_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && go && (cmd == CMD_PRE) && (state == BK_IDLE)) |=> (state == BK_IDLE));

  a_r10_prechg_expires: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !go && (state == BK_PRECHG) && (cnt == '0)) |=> (state == BK_IDLE));

  a_r11_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick) |=> $stable(state));
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int TRP_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [1:0]       ba,
  input  logic [ROW_W-1:0] addr,
  input  logic [1:0]       bl_sel,
  output logic             res_valid,
  output logic [2:0]       res_cmd,
  output logic [1:0]       res_bank,
  output logic [ROW_W-1:0] res_addr,
  output logic             res_auto_pre,
  output logic             res_all_banks,
  output logic             res_illegal
);
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 2;
  localparam int MAX_CNT   = (TRP_CYC > 8) ? TRP_CYC : 8;
  localparam int CNT_W     = $clog2(MAX_CNT);

  cmd_e              cmd;
  logic              cke_q;
  logic              accept;
  logic              legal;
  logic              bad;
  logic              all_idle;
  logic [BANK_W-1:0] tgt;
  logic [CNT_W-1:0]  bl_m1;
  logic [ROW_W-1:0]  addr_sel;
  logic [NUM_BANKS-1:0] rw_bad, act_bad, idle_v, bank_go;

  sdram_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  assign accept = cke_q && (cmd != CMD_DESEL);
  assign tgt    = {ba[0], ba[1]};
  assign bl_m1  = CNT_W'((1 << bl_sel) - 1);

  always_comb begin
    unique case (cmd)
      CMD_READ, CMD_WRITE: bad = rw_bad[tgt];
      CMD_ACT:             bad = act_bad[tgt];
      CMD_REF, CMD_MRS:    bad = !all_idle;
      default:             bad = 1'b0;
    endcase
  end

  assign legal    = accept && !bad;
  assign all_idle = &idle_v;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bank_st_e st;
    assign bank_go[g] = legal &&
      (((cmd == CMD_PRE) && addr[QUAL_BIT]) ||
       (((cmd == CMD_READ) || (cmd == CMD_WRITE) ||
         (cmd == CMD_ACT) || (cmd == CMD_PRE)) && (tgt == BANK_W'(g))));
    assign idle_v[g] = (st == BK_IDLE);

    sdram_bank_tracker #(
      .CNT_W  (CNT_W),
      .TRP_CYC(TRP_CYC)
    ) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (cke_q),
      .go     (bank_go[g]),
      .cmd    (cmd),
      .ap_in  (addr[QUAL_BIT]),
      .bl_m1  (bl_m1),
      .state  (st),
      .rw_bad (rw_bad[g]),
      .act_bad(act_bad[g])
    );
  end

  always_comb begin
    unique case (cmd)
      CMD_READ, CMD_WRITE: addr_sel = ROW_W'(addr[COL_W-1:0]);
      default:             addr_sel = addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_cmd       <= '0;
      res_bank      <= '0;
      res_addr      <= '0;
      res_auto_pre  <= 1'b0;
      res_all_banks <= 1'b0;
      res_illegal   <= 1'b0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_cmd       <= cmd;
        res_bank      <= tgt;
        res_addr      <= addr_sel;
        res_auto_pre  <= addr[QUAL_BIT] && ((cmd == CMD_READ) || (cmd == CMD_WRITE));
        res_all_banks <= addr[QUAL_BIT] && (cmd == CMD_PRE);
        res_illegal   <= bad;
      end else begin
        res_illegal   <= 1'b0;
      end
    end
  end

  a_r1_deselect_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !res_valid);

  a_r11_suspended_edge_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ##1 !res_valid);

  a_r7_refresh_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ((cmd == CMD_REF) || (cmd == CMD_MRS)) && !all_idle)
      |=> (res_valid && res_illegal));
endmodule

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [1:0]  bl_sel = 2'd2;
  logic        res_valid, res_auto_pre, res_all_banks, res_illegal;
  logic [2:0]  res_cmd;
  logic [1:0]  res_bank;
  logic [12:0] res_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [20:0] exp_q[$];
  string       tag_q[$];

  localparam logic [2:0] P_NOP = 3'b111, P_BST = 3'b110, P_RD = 3'b101, P_WR = 3'b100,
                         P_ACT = 3'b011, P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000;

  always #5 clk = ~clk;

  sdram_cmd_monitor uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .bl_sel(bl_sel),
    .res_valid(res_valid), .res_cmd(res_cmd), .res_bank(res_bank),
    .res_addr(res_addr), .res_auto_pre(res_auto_pre),
    .res_all_banks(res_all_banks), .res_illegal(res_illegal)
  );

  // Driver: ba_i[0] is BA0; expected bank computed per R3 as {BA0,BA1}
  task automatic issue(input logic [2:0] pins, input logic [1:0] ba_i,
                       input logic [12:0] a, input logic [2:0] ecmd,
                       input logic [12:0] eaddr, input logic eap, input logic eall,
                       input logic eill, input string tag);
    @(negedge clk);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = pins; ba = ba_i; addr = a;
    exp_q.push_back({ecmd, {ba_i[0], ba_i[1]}, eaddr, eap, eall, eill});
    tag_q.push_back(tag);
  endtask

  task automatic desel(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs_n = 1'b1; {ras_n, cas_n, we_n} = P_ACT; addr = 13'h1FFF;  // R1: pins ignored
    end
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (res_valid) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R1/R11 unexpected report: got cmd=%0d expected none", res_cmd);
        end else begin
          logic [20:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({res_cmd, res_bank, res_addr, res_auto_pre, res_all_banks, res_illegal} !== e) begin
            n_fail++;
            $display("FAIL %s: got cmd=%0d bank=%0d addr=%h ap=%b all=%b ill=%b expected cmd=%0d bank=%0d addr=%h ap=%b all=%b ill=%b",
                     t, res_cmd, res_bank, res_addr, res_auto_pre, res_all_banks, res_illegal,
                     e[20:18], e[17:16], e[15:3], e[2], e[1], e[0]);
          end
        end
      end else if (exp_q.size() != 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL %s: got no report expected res_valid=1", tag_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    if (res_valid !== 1'b0 || res_illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 reset: got valid=%b ill=%b expected 0 0", res_valid, res_illegal);
    end
    // R2 decode, NOP variants
    issue(P_NOP, 2'b00, 13'h0, 3'd0, 13'h0, 0, 0, 0, "R2 nop");
    issue(P_BST, 2'b00, 13'h0, 3'd0, 13'h0, 0, 0, 0, "R2 110 as nop");
    // R6 read to idle bank
    issue(P_RD, 2'b00, 13'h0, 3'd1, 13'h0, 0, 0, 1, "R6 read idle bank");
    // R4 row address
    issue(P_ACT, 2'b00, 13'h1ABC, 3'd3, 13'h1ABC, 0, 0, 0, "R4 activate row");
    issue(P_ACT, 2'b00, 13'h0, 3'd3, 13'h0, 0, 0, 1, "R6 activate open bank");
    // R3 mapping: BA0=0,BA1=1 -> bank1 ; BA0=1,BA1=0 -> bank2
    issue(P_ACT, 2'b10, 13'h0, 3'd3, 13'h0, 0, 0, 0, "R3 bank1 mapping");
    issue(P_ACT, 2'b01, 13'h0, 3'd3, 13'h0, 0, 0, 0, "R3 bank2 mapping");
    issue(P_REF, 2'b00, 13'h0, 3'd5, 13'h0, 0, 0, 1, "R7 refresh with open rows");
    // R4 column address: high bits dropped
    issue(P_RD, 2'b00, 13'h11F5, 3'd1, 13'h01F5, 0, 0, 0, "R4 read column");
    issue(P_RD, 2'b00, 13'h0002, 3'd1, 13'h0002, 0, 0, 0, "R9 read restarts read");
    issue(P_WR, 2'b00, 13'h0003, 3'd2, 13'h0003, 0, 0, 0, "R9 write ends read");
    issue(P_PRE, 2'b00, 13'h0, 3'd4, 13'h0, 0, 0, 0, "R8 precharge bank0");
    issue(P_RD, 2'b00, 13'h0, 3'd1, 13'h0, 0, 0, 1, "R6 read precharging bank");
    issue(P_PRE, 2'b00, 13'h0, 3'd4, 13'h0, 0, 0, 0, "R8 precharge on precharging");
    desel(2);
    issue(P_ACT, 2'b00, 13'h0055, 3'd3, 13'h0055, 0, 0, 0, "R10 bank0 idle after TRP");
    // R5 / R9 auto-precharge write, BL4
    issue(P_WR, 2'b00, 13'h0404, 3'd2, 13'h0004, 1, 0, 0, "R5 write auto-pre");
    issue(P_WR, 2'b00, 13'h0005, 3'd2, 13'h0005, 0, 0, 1, "R9 write during auto-pre burst");
    desel(8);
    issue(P_ACT, 2'b00, 13'h0, 3'd3, 13'h0, 0, 0, 0, "R10 auto-pre returns idle");
    issue(P_PRE, 2'b11, 13'h0400, 3'd4, 13'h0400, 0, 1, 0, "R5 precharge all");
    desel(4);
    issue(P_REF, 2'b00, 13'h0, 3'd5, 13'h0, 0, 0, 0, "R7 refresh all idle");
    issue(P_MRS, 2'b00, 13'h0033, 3'd6, 13'h0033, 0, 0, 0, "R7 mode set all idle");
    // R11 clock suspend: command on suspended edge ignored
    @(negedge clk); cke = 1'b0; cs_n = 1'b1;
    @(negedge clk); cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = P_ACT; ba = 2'b11; addr = '0;
    issue(P_ACT, 2'b11, 13'h0, 3'd3, 13'h0, 0, 0, 0, "R11 suspended activate ignored");
    // R10 BL1 read with auto-precharge, boundary of TRP
    @(negedge clk); bl_sel = 2'd0;
    cs_n = 1'b0; {ras_n, cas_n, we_n} = P_RD; ba = 2'b11; addr = 13'h0407;
    exp_q.push_back({3'd1, 2'd3, 13'h0007, 1'b1, 1'b0, 1'b0}); tag_q.push_back("R10 BL1 read auto-pre");
    desel(3);
    issue(P_ACT, 2'b11, 13'h0, 3'd3, 13'h0, 0, 0, 1, "R10 last precharge cycle");
    issue(P_ACT, 2'b11, 13'h0, 3'd3, 13'h0, 0, 0, 0, "R10 idle after precharge");
    desel(4);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R12 drain: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule